// File: doc/BRIEF.md
# Shadow Register Commit Engine

This block holds a local shadow copy of a bank of configuration registers that belong to an external device programmed over a write-only serial link. Next to every shadow entry it keeps a dirty flag. A host drives one request stream and can do four things with it: read a shadow entry back, stage a new value in the shadow without touching the link, write a value and send it at once, or start a commit that pushes every staged change out to the device.

Each register goes out as one serial word. The data sits in the upper part of the word and the register index in the lowest bits. The word is split into two equal frames, and each frame has its own chip-select window. Out of reset, the shadow is loaded from a parameter array, every flag is raised and a full commit runs on its own. The host can therefore rely on the device matching the shadow once `busy` first falls.

The request interface is valid/ready. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for as long as the engine is sending, so back-pressure covers the whole duration of a commit or an immediate write. While ready is low, the host holds its request and its fields stable. Read responses come back as a one-cycle `rd_valid` pulse and cannot be stalled.

Top module: `shadow_commit_engine`

## Requirements
- R1: After reset, shadow entry i holds the low 14 bits of the i-th 16-bit slice of the default parameter, all flags are set, and the engine on its own sends all 16 registers in ascending index order, with `busy` high until the last one is sent.
- R2: The serial word is 18 bits: bits 17:4 carry the 14 data bits and bits 3:0 carry the register index.
- R3: Each word goes out as two 9-bit frames, word bits 17:9 first and then bits 8:0, each frame MSB first. Chip select is low only within a frame and goes high between the two frames. `spi_sck` idles low, and `spi_mosi` changes only while `spi_sck` is low, so the device samples it on the rising edge.
- R4: Bits 15:14 of `req_data` are discarded. A readback returns them as zero.
- R5: A read request (op 0) is answered with `rd_valid` high in the cycle after acceptance, with `rd_data` holding the shadow entry. It causes no link activity and does not raise `busy`.
- R6: A stage request (op 2) replaces the shadow entry and sets its flag, causes no link activity and does not raise `busy`.
- R7: A commit request (op 3) sends only flagged registers, in ascending index order, and clears each flag once its word is sent. A commit with no flag set sends nothing.
- R8: A send-now request (op 1) stores the value and immediately sends exactly that one register. Its flag ends up clear, even if it had been staged before, so a following commit does not send it.
- R9: `req_ready` is low whenever `busy` is high. A request held during that time is taken only on the first cycle in which ready returns high.
- R10: `busy` rises in the cycle after a commit or send-now is accepted, stays high at least for both frames of every word sent, and chip select stays high whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (low while busy) |
| req_op | input | 2 | 0 read, 1 send-now, 2 stage, 3 commit |
| req_addr | input | 4 | Register index |
| req_data | input | 16 | Write value; only bits 13:0 are kept |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 16 | Read response, zero-extended shadow entry |
| busy | output | 1 | Commit or send-now in progress |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |

## Verification
The hardest case to reach from the ports is a commit that must skip some entries and send others in a sparse, irregular pattern, together with the interplay between a staged flag and a later send-now on the same index. The bench drives a sweep of computed masks. For each mask it stages the selected entries, commits, and decodes the serial stream back into words to compare against an arithmetic model of the shadow and flags. It also stages an entry, sends it at once, and then commits, to show that the flag was cleared. Back-pressure is exercised by holding a stage request while a send-now is in flight.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_SEND   = 2'd1,
    OP_STAGE  = 2'd2,
    OP_COMMIT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SCAN,
    SQ_LOAD,
    SQ_WAIT
  } seq_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SHIFT,
    TX_GAP
  } tx_e;
endpackage

// File: rtl/scm_shadow.sv
module scm_shadow #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 14,
  parameter int HOST_W   = 16,
  parameter int ADDR_W   = 4,
  parameter logic [NUM_REGS*HOST_W-1:0] DEFAULTS = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                wr_dirty,
  input  logic                clr_en,
  input  logic [ADDR_W-1:0]   clr_addr,
  input  logic [ADDR_W-1:0]   rd_a_addr,
  output logic [DATA_W-1:0]   rd_a_data,
  input  logic [ADDR_W-1:0]   rd_b_addr,
  output logic [DATA_W-1:0]   rd_b_data,
  output logic [NUM_REGS-1:0] dirty
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        mem[i]   <= DEFAULTS[i*HOST_W +: DATA_W];
        dirty[i] <= 1'b1;
      end
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_en && wr_addr == ADDR_W'(i)) begin
          mem[i]   <= wr_data;
          dirty[i] <= wr_dirty;
        end else if (clr_en && clr_addr == ADDR_W'(i)) begin
          dirty[i] <= 1'b0;
        end
      end
    end
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/scm_spi_frame.sv
module scm_spi_frame
  import scm_pkg::*;
#(
  parameter int FRAME_W  = 9,
  parameter int WORD_W   = 18,
  parameter int SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              done,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi
);
  localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  tx_e                state;
  logic [DIV_W-1:0]   divcnt;
  logic [BIT_W-1:0]   bitcnt;
  logic [FRAME_W-1:0] sh;
  logic [FRAME_W-1:0] lo_part;
  logic               second;
  logic               tick;

  assign tick = (divcnt == DIV_W'(SCK_HALF - 1));
  assign mosi = cs_n ? 1'b0 : sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      divcnt  <= '0;
      bitcnt  <= '0;
      sh      <= '0;
      lo_part <= '0;
      second  <= 1'b0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == TX_IDLE) begin
        if (start) begin
          sh      <= word[WORD_W-1 -: FRAME_W];
          lo_part <= word[FRAME_W-1:0];
          cs_n    <= 1'b0;
          sck     <= 1'b0;
          bitcnt  <= '0;
          second  <= 1'b0;
          divcnt  <= '0;
          state   <= TX_SHIFT;
        end
      end else begin
        divcnt <= tick ? '0 : divcnt + DIV_W'(1);
        if (tick) begin
          if (state == TX_SHIFT) begin
            if (!sck) begin
              sck <= 1'b1;
            end else begin
              sck <= 1'b0;
              if (bitcnt == BIT_W'(FRAME_W - 1)) begin
                cs_n  <= 1'b1;
                state <= TX_GAP;
              end else begin
                sh     <= sh << 1;
                bitcnt <= bitcnt + BIT_W'(1);
              end
            end
          end else begin
            if (!second) begin
              second <= 1'b1;
              sh     <= lo_part;
              cs_n   <= 1'b0;
              bitcnt <= '0;
              state  <= TX_SHIFT;
            end else begin
              state <= TX_IDLE;
              done  <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/scm_sequencer.sv
module scm_sequencer
  import scm_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 14,
  parameter int ADDR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_fire,
  input  logic [1:0]                 req_op,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [NUM_REGS-1:0]        dirty,
  input  logic [DATA_W-1:0]          cur_data,
  output logic [ADDR_W-1:0]          cur_addr,
  output logic                       tx_start,
  output logic [DATA_W+ADDR_W-1:0]   tx_word,
  input  logic                       tx_done,
  output logic                       clr_en,
  output logic                       busy
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);

  seq_e              state;
  logic [ADDR_W-1:0] idx;
  logic              one_shot;

  assign cur_addr = idx;
  assign tx_word  = {cur_data, idx};
  assign tx_start = (state == SQ_LOAD) || (state == SQ_SCAN && dirty[idx]);
  assign clr_en   = (state == SQ_WAIT) && tx_done && !one_shot;
  assign busy     = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_SCAN;
      idx      <= '0;
      one_shot <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (req_fire && req_op == OP_COMMIT) begin
            idx      <= '0;
            one_shot <= 1'b0;
            state    <= SQ_SCAN;
          end else if (req_fire && req_op == OP_SEND) begin
            idx      <= req_addr;
            one_shot <= 1'b1;
            state    <= SQ_LOAD;
          end
        end
        SQ_SCAN: begin
          if (dirty[idx]) begin
            state <= SQ_WAIT;
          end else if (idx == LAST) begin
            state <= SQ_IDLE;
          end else begin
            idx <= idx + ADDR_W'(1);
          end
        end
        SQ_LOAD: state <= SQ_WAIT;
        SQ_WAIT: begin
          if (tx_done) begin
            if (one_shot || idx == LAST) begin
              state <= SQ_IDLE;
            end else begin
              idx   <= idx + ADDR_W'(1);
              state <= SQ_SCAN;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shadow_commit_engine.sv
module shadow_commit_engine
  import scm_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 14,
  parameter int HOST_W   = 16,
  parameter int FRAME_W  = 9,
  parameter int SCK_HALF = 2,
  parameter logic [NUM_REGS*HOST_W-1:0] DEFAULTS = {
    16'h0E21, 16'h1B44, 16'h0A5A, 16'h3C0F, 16'h2222, 16'h1111, 16'h0F0F, 16'h3FFF,
    16'h0001, 16'h2468, 16'h1357, 16'h0ACE, 16'h3210, 16'h1F80, 16'h0642, 16'h2BCD
  }
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_op,
  input  logic [$clog2(NUM_REGS)-1:0]   req_addr,
  input  logic [HOST_W-1:0]             req_data,
  output logic                          rd_valid,
  output logic [HOST_W-1:0]             rd_data,
  output logic                          busy,
  output logic                          spi_sck,
  output logic                          spi_cs_n,
  output logic                          spi_mosi
);
  localparam int ADDR_W = $clog2(NUM_REGS);
  localparam int WORD_W = DATA_W + ADDR_W;

  logic                accept;
  logic                wr_en;
  logic [DATA_W-1:0]   rd_a_data;
  logic [DATA_W-1:0]   cur_data;
  logic [ADDR_W-1:0]   cur_addr;
  logic [NUM_REGS-1:0] dirty;
  logic                clr_en;
  logic                tx_start;
  logic                tx_done;
  logic [WORD_W-1:0]   tx_word;
  logic                unused_hi;

  assign unused_hi = ^req_data[HOST_W-1:DATA_W];
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && (req_op == OP_SEND || req_op == OP_STAGE);

  scm_shadow #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .HOST_W   (HOST_W),
    .ADDR_W   (ADDR_W),
    .DEFAULTS (DEFAULTS)
  ) shadow_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (req_addr),
    .wr_data   (req_data[DATA_W-1:0]),
    .wr_dirty  (req_op == OP_STAGE),
    .clr_en    (clr_en),
    .clr_addr  (cur_addr),
    .rd_a_addr (req_addr),
    .rd_a_data (rd_a_data),
    .rd_b_addr (cur_addr),
    .rd_b_data (cur_data),
    .dirty     (dirty)
  );

  scm_sequencer #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (accept),
    .req_op   (req_op),
    .req_addr (req_addr),
    .dirty    (dirty),
    .cur_data (cur_data),
    .cur_addr (cur_addr),
    .tx_start (tx_start),
    .tx_word  (tx_word),
    .tx_done  (tx_done),
    .clr_en   (clr_en),
    .busy     (busy)
  );

  scm_spi_frame #(
    .FRAME_W  (FRAME_W),
    .WORD_W   (WORD_W),
    .SCK_HALF (SCK_HALF)
  ) spi_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tx_start),
    .word  (tx_word),
    .done  (tx_done),
    .sck   (spi_sck),
    .cs_n  (spi_cs_n),
    .mosi  (spi_mosi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= accept && req_op == OP_READ;
      if (accept && req_op == OP_READ) begin
        rd_data <= HOST_W'(rd_a_data);
      end
    end
  end
endmodule

// File: rtl/scm_checker.sv
module scm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic       busy,
  input logic       rd_valid,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic       spi_mosi
);
  // R3
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R3
  mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sck) |-> $stable(spi_mosi));

  // R10
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);

  // R5
  read_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0) |=> rd_valid);

  // R6
  stage_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd2) |=> !busy);

  // R10
  send_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op[0]) |=> busy);

  // R9
  no_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
endmodule

bind shadow_commit_engine scm_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .spi_sck   (spi_sck),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi)
);

// File: tb/shadow_commit_engine_tb_top.sv
module shadow_commit_engine_tb_top;
  localparam int N = 16;

  function automatic logic [N*16-1:0] mk_def();
    logic [N*16-1:0] v;
    for (int i = 0; i < N; i++) v[i*16 +: 16] = 16'(i * 16'h1357) ^ 16'hC0A5;
    return v;
  endfunction
  localparam logic [N*16-1:0] DEF = mk_def();

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [3:0] req_addr = 0;
  logic [15:0] req_data = 0;
  logic rd_valid, busy, spi_sck, spi_cs_n, spi_mosi;
  logic [15:0] rd_data;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [13:0] exp_sh [N];
  logic [17:0] log_w [1024];
  int nw = 0;
  int nbits = 0;
  int half = 0;
  logic [8:0] fbits, hi_f;

  always #2.5 clk = ~clk;

  shadow_commit_engine #(.SCK_HALF(1), .DEFAULTS(DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi));

  // serial decoder
  always @(negedge spi_cs_n) begin nbits = 0; fbits = '0; end
  always @(posedge spi_sck) if (!spi_cs_n) begin fbits = {fbits[7:0], spi_mosi}; nbits++; end
  always @(posedge spi_cs_n) if (nbits > 0) begin
    checks++;
    if (nbits != 9) begin
      failures++;
      $display("FAIL R3 frame length act=%0d exp=9", nbits);
    end
    if (half == 0) begin hi_f = fbits; half = 1; end
    else begin
      if (nw < 1024) log_w[nw] = {hi_f, fbits};
      nw++; half = 0;
    end
    nbits = 0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int a, input logic [15:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a[3:0]; req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_check(input int a, input string tag);
    issue(2'd0, a, 16'h0);
    chk(rd_valid === 1'b1, {tag, " rd_valid"}, 32'(rd_valid), 1);
    chk(rd_data === {2'b00, exp_sh[a]}, {tag, " rd_data"}, 32'(rd_data), 32'(exp_sh[a]));
  endtask

  // check words log[base..] against registers selected in mask
  task automatic words_check(input int base, input logic [15:0] mask, input string tag);
    int k = base;
    chk(nw - base == $countones(mask), {tag, " word count"}, 32'(nw - base), 32'($countones(mask)));
    for (int i = 0; i < N; i++) if (mask[i]) begin
      if (k < nw) chk(log_w[k] === {exp_sh[i], 4'(i)}, {tag, " word"}, 32'(log_w[k]), 32'({exp_sh[i], 4'(i)}));
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base, waited;
    logic [15:0] mask, d;
    for (int i = 0; i < N; i++) exp_sh[i] = DEF[i*16 +: 14];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: busy out of reset, startup commit of all registers (R2 word layout)
    chk(busy === 1'b1, "R1 busy after reset", 32'(busy), 1);
    chk(req_ready === 1'b0, "R9 ready low while busy", 32'(req_ready), 0);
    wait_idle();
    words_check(0, 16'hFFFF, "R1 R2 R3 startup");

    // R5: read sweep, no link activity
    base = nw;
    for (int i = 0; i < N; i++) rd_check(i, "R5 R1 default");
    chk(nw == base, "R5 no link activity", 32'(nw - base), 0);

    // R7: empty commit sends nothing
    base = nw;
    issue(2'd3, 0, 0);
    chk(busy === 1'b1, "R10 busy on commit", 32'(busy), 1);
    wait_idle();
    chk(nw == base, "R7 empty commit", 32'(nw - base), 0);

    // R6 / R4: stage odd indices with high bits set
    base = nw;
    for (int i = 1; i < N; i += 2) begin
      d = 16'hC000 | 16'(i * 16'h0321);
      issue(2'd2, i, d);
      chk(busy === 1'b0, "R6 stage no busy", 32'(busy), 0);
      exp_sh[i] = d[13:0];
    end
    repeat (4) @(negedge clk);
    chk(nw == base, "R6 stage silent", 32'(nw - base), 0);
    rd_check(3, "R4 high bits dropped");
    issue(2'd3, 0, 0);
    wait_idle();
    words_check(base, 16'hAAAA, "R7 odd commit");
    base = nw;
    issue(2'd3, 0, 0);
    wait_idle();
    chk(nw == base, "R7 flags cleared", 32'(nw - base), 0);

    // R8: send-now, and send-now of a staged register clears its flag
    base = nw;
    exp_sh[5] = 14'h2A5C;
    issue(2'd1, 5, 16'hEA5C);
    wait_idle();
    words_check(base, 16'h0020, "R8 send-now");
    base = nw;
    issue(2'd2, 3, 16'h0123);
    exp_sh[3] = 14'h0123;
    exp_sh[3] = 14'h1777;
    issue(2'd1, 3, 16'h1777);
    wait_idle();
    words_check(base, 16'h0008, "R8 staged then sent");
    base = nw;
    issue(2'd3, 0, 0);
    wait_idle();
    chk(nw == base, "R8 flag left clear", 32'(nw - base), 0);

    // R9 / R10: request held during busy
    base = nw;
    exp_sh[9] = 14'h0BEE;
    issue(2'd1, 9, 16'h0BEE);
    req_valid = 1; req_op = 2'd2; req_addr = 4'd7; req_data = 16'h3131;
    waited = 0;
    while (!req_ready) begin
      if (busy !== 1'b1) begin chk(0, "R9 ready low only when busy", 32'(busy), 1); end
      waited++;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
    exp_sh[7] = 14'h3131;
    chk(waited >= 36, "R10 busy covers two frames", 32'(waited), 36);
    words_check(base, 16'h0200, "R9 send during hold");
    rd_check(7, "R9 held stage taken");
    base = nw;
    issue(2'd3, 0, 0);
    wait_idle();
    words_check(base, 16'h0080, "R9 held stage dirty");

    // R7 sweep over computed masks
    for (int m = 0; m < 20; m++) begin
      mask = 16'((m + 1) * 16'h2C65) ^ 16'(m << 7);
      base = nw;
      for (int i = 0; i < N; i++) if (mask[i]) begin
        d = 16'(m * 16'h0731 + i * 16'h0107) | 16'hC000;
        issue(2'd2, i, d);
        exp_sh[i] = d[13:0];
      end
      issue(2'd3, 0, 0);
      wait_idle();
      words_check(base, mask, "R7 R2 sweep");
      if (m % 5 == 0) for (int i = 0; i < N; i++) rd_check(i, "R4 R6 sweep read");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule